// File: doc/BRIEF.md
# Connection Memory Block-Fill Engine

This block sets every location of a switch's connection memory to one known pattern, so that software does not have to write thousands of entries one by one after power-up. Each location holds a low word and a high word. The engine sweeps the address space one location per clock. It writes a 3-bit value into the bottom of each low word, and it writes zero everywhere else, including the whole high word. While the engine is not active, ordinary processor writes to the memory pass through the same write port.

Software uses two small registers. The control register holds an arm bit. The mode register holds a start bit and the 3-bit fill value. A fill begins when software raises the start bit while the arm bit is already set. The fill lasts at least two frame periods, counted by frame pulses. When it finishes, the start bit drops back to zero by itself. The arm bit stays set until software clears it. If software clears either bit before the end, the fill stops at once. If the arm bit was cleared while start was still set, the engine reports a blocked status until software also clears start. Processor writes to the memory are refused while the engine is busy, armed or blocked.

Top module: `cm_fill_engine`

## Requirements
- R1: After reset the arm, start, busy and blocked status bits are all 0 and no memory write strobe is active.
- R2: Register writes use reg_addr 0 for the control register, where bit 3 is the arm bit. They use reg_addr 1 for the mode register, where bit 0 is the start bit and bits 3..1 are the fill value. A fill begins only when start goes from 0 to 1 while arm is already 1. A start written while arm is 0 begins no fill and makes no memory write.
- R3: During a fill, one location is written per clock, from address 0 up to DEPTH-1. Each low word receives the fill value in bits 2..0 and zero in bits 15..3. Each high word receives all zeros.
- R4: Busy stays high until a frame pulse arrives when two conditions both hold: the sweep is over, and two frame pulses have already been counted since the start. Busy falls at that pulse and not before.
- R5: When a fill completes, the start bit clears by itself and the arm bit stays at 1.
- R6: Writing start = 0 during a fill ends it. The location written on the same clock as that register write is the last one. Busy is 0 afterwards.
- R7: Writing arm = 0 during a fill ends it in the same way. Start stays at 1, and blocked reads 1 for as long as start is 1 while arm is 0. Clearing start removes blocked.
- R8: A processor write is refused, with cpu_rej high and no strobe issued, while busy, arm or blocked is 1. An accepted write stores the low word as given. It stores only bits 4..0 of the high word, and reserved high bits 15..5 are written as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | One-cycle frame boundary pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 mode |
| reg_wdata | input | 4 | Register write data |
| cpu_wr_lo | input | 1 | Processor write request, low word |
| cpu_wr_hi | input | 1 | Processor write request, high word |
| cpu_addr | input | AW | Processor write address |
| cpu_dlo | input | DATA_W | Processor low-word data |
| cpu_dhi | input | DATA_W | Processor high-word data |
| cm_we_lo | output | 1 | Memory low-word write strobe |
| cm_we_hi | output | 1 | Memory high-word write strobe |
| cm_addr | output | AW | Memory write address |
| cm_dlo | output | DATA_W | Memory low-word write data |
| cm_dhi | output | DATA_W | Memory high-word write data |
| cpu_rej | output | 1 | Processor write refused this cycle |
| stat_busy | output | 1 | Fill in progress |
| stat_arm | output | 1 | Arm bit readback |
| stat_start | output | 1 | Start bit readback |
| stat_blocked | output | 1 | Start left set after an arm abort |
| stat_fill_val | output | FILL_W | Fill value readback |

## Verification
A sweep counter that skips or repeats an address would leave a stale location. The memory model shows this as soon as the fill ends, and an out-of-order strobe shows it on the very clock it happens. A frame counter that counts wrongly moves the falling edge of busy by at least one whole frame pulse. A fault in the abort logic shows up on the clock after the register write: write strobes keep running, or start and blocked hold the wrong values. A gating fault shows on cpu_rej in the same cycle as the processor request.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
   // register map shared by the decode logic and its users
   localparam int   REG_DW         = 4;
   localparam logic REG_CTRL       = 1'b0;
   localparam logic REG_MODE       = 1'b1;
   localparam int   CTRL_ARM_BIT   = 3;
   localparam int   MODE_START_BIT = 0;
   localparam int   MODE_VAL_LSB   = 1;
endpackage

// File: rtl/cmf_regs.sv
module cmf_regs
   import cmf_pkg::*;
#(
   parameter int FILL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   input  logic              done,
   output logic              launch,
   output logic              arm,
   output logic              start,
   output logic              busy,
   output logic              blocked,
   output logic [FILL_W-1:0] fill_val
);
   logic              ctrl_wr, mode_wr, arm_wbit, start_wbit, abort;
   logic              arm_q, start_q, busy_q;
   logic [FILL_W-1:0] val_q;

   assign ctrl_wr    = reg_wr && (reg_addr == REG_CTRL);
   assign mode_wr    = reg_wr && (reg_addr == REG_MODE);
   assign arm_wbit   = reg_wdata[CTRL_ARM_BIT];
   assign start_wbit = reg_wdata[MODE_START_BIT];

   // a fill needs a fresh rising start with arm already set
   assign launch = mode_wr && start_wbit && !start_q && arm_q && !busy_q;
   // clearing either gate bit while running stops the sweep at once
   assign abort  = busy_q && ((ctrl_wr && !arm_wbit) || (mode_wr && !start_wbit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q   <= 1'b0;
         start_q <= 1'b0;
         busy_q  <= 1'b0;
         val_q   <= '0;
      end else begin
         if (ctrl_wr) arm_q <= arm_wbit;
         if (mode_wr)   start_q <= start_wbit;
         else if (done) start_q <= 1'b0;
         if (mode_wr && !busy_q) val_q <= reg_wdata[MODE_VAL_LSB +: FILL_W];
         if (launch)             busy_q <= 1'b1;
         else if (abort || done) busy_q <= 1'b0;
      end
   end

   assign arm      = arm_q;
   assign start    = start_q;
   assign busy     = busy_q;
   assign blocked  = start_q && !arm_q;
   assign fill_val = val_q;

   // R2
   launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (arm_q && start_q));
   // R5
   self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_q) && !$past(abort)) |-> (!start_q && arm_q));
   // R6
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy_q);
   // R7
   blocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && !arm_q) |-> !busy_q);
endmodule

// File: rtl/cmf_sweep.sv
module cmf_sweep #(
   parameter int DEPTH      = 2048,
   parameter int MIN_FRAMES = 2,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          busy,
   input  logic          frame_pulse,
   output logic          fill_we,
   output logic [AW-1:0] fill_addr,
   output logic          done
);
   localparam int            FCW  = $clog2(MIN_FRAMES + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [FCW-1:0] FMAX = FCW'(MIN_FRAMES);

   logic [AW-1:0]  addr_q;
   logic           swept_q;
   logic [FCW-1:0] fcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         swept_q <= 1'b1;
         fcnt_q  <= '0;
      end else if (launch) begin
         addr_q  <= '0;
         swept_q <= 1'b0;
         fcnt_q  <= '0;
      end else if (busy) begin
         if (!swept_q) begin
            if (addr_q == LAST) swept_q <= 1'b1;
            else                addr_q  <= addr_q + 1'b1;
         end
         if (frame_pulse && (fcnt_q < FMAX)) fcnt_q <= fcnt_q + 1'b1;
      end
   end

   assign fill_we   = busy && !swept_q;
   assign fill_addr = addr_q;
   // completion only on a frame boundary once both conditions are met
   assign done      = busy && frame_pulse && swept_q && (fcnt_q == FMAX);

   // R3
   sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_we && (addr_q != LAST) && !launch) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/cmf_wport.sv
module cmf_wport #(
   parameter int DEPTH      = 2048,
   parameter int DATA_W     = 16,
   parameter int FILL_W     = 3,
   parameter int HI_FIELD_W = 5,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic              fill_we,
   input  logic [AW-1:0]     fill_addr,
   input  logic [FILL_W-1:0] fill_val,
   input  logic              locked,
   input  logic              cpu_wr_lo,
   input  logic              cpu_wr_hi,
   input  logic [AW-1:0]     cpu_addr,
   input  logic [DATA_W-1:0] cpu_dlo,
   input  logic [DATA_W-1:0] cpu_dhi,
   output logic              cm_we_lo,
   output logic              cm_we_hi,
   output logic [AW-1:0]     cm_addr,
   output logic [DATA_W-1:0] cm_dlo,
   output logic [DATA_W-1:0] cm_dhi,
   output logic              cpu_rej
);
   localparam logic [DATA_W-1:0] HI_MASK = {DATA_W{1'b1}} >> (DATA_W - HI_FIELD_W);

   logic [DATA_W-1:0] fill_lo;
   logic              cpu_req, cpu_ok;

   generate
      if (FILL_W == DATA_W) begin : g_full_lo
         assign fill_lo = fill_val;
      end else begin : g_pad_lo
         assign fill_lo = {{(DATA_W - FILL_W){1'b0}}, fill_val};
      end
   endgenerate

   assign cpu_req  = cpu_wr_lo || cpu_wr_hi;
   assign cpu_ok   = !locked && !fill_we;
   assign cpu_rej  = cpu_req && !cpu_ok;

   assign cm_we_lo = fill_we || (cpu_wr_lo && cpu_ok);
   assign cm_we_hi = fill_we || (cpu_wr_hi && cpu_ok);
   assign cm_addr  = fill_we ? fill_addr : cpu_addr;
   assign cm_dlo   = fill_we ? fill_lo : cpu_dlo;
   assign cm_dhi   = fill_we ? '0 : (cpu_dhi & HI_MASK);
endmodule

// File: rtl/cm_fill_engine.sv
module cm_fill_engine
   import cmf_pkg::*;
#(
   parameter int DEPTH      = 2048,
   parameter int DATA_W     = 16,
   parameter int FILL_W     = 3,
   parameter int HI_FIELD_W = 5,
   parameter int MIN_FRAMES = 2,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_pulse,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   input  logic              cpu_wr_lo,
   input  logic              cpu_wr_hi,
   input  logic [AW-1:0]     cpu_addr,
   input  logic [DATA_W-1:0] cpu_dlo,
   input  logic [DATA_W-1:0] cpu_dhi,
   output logic              cm_we_lo,
   output logic              cm_we_hi,
   output logic [AW-1:0]     cm_addr,
   output logic [DATA_W-1:0] cm_dlo,
   output logic [DATA_W-1:0] cm_dhi,
   output logic              cpu_rej,
   output logic              stat_busy,
   output logic              stat_arm,
   output logic              stat_start,
   output logic              stat_blocked,
   output logic [FILL_W-1:0] stat_fill_val
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cm_fill_engine: DEPTH must be at least 2");
      end
      if (MIN_FRAMES < 1) begin : g_bad_frames
         $error("cm_fill_engine: MIN_FRAMES must be at least 1");
      end
      if ((FILL_W > DATA_W) || (HI_FIELD_W > DATA_W) || (HI_FIELD_W < 1)) begin : g_bad_width
         $error("cm_fill_engine: field widths exceed the data word");
      end
      if (MODE_VAL_LSB + FILL_W > REG_DW) begin : g_bad_reg
         $error("cm_fill_engine: fill value does not fit the mode register");
      end
   endgenerate

   logic              launch, done, fill_we;
   logic              arm, start, busy, blocked;
   logic [AW-1:0]     fill_addr;
   logic [FILL_W-1:0] fill_val;

   cmf_regs #(.FILL_W(FILL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .done     (done),
      .launch   (launch),
      .arm      (arm),
      .start    (start),
      .busy     (busy),
      .blocked  (blocked),
      .fill_val (fill_val)
   );

   cmf_sweep #(.DEPTH(DEPTH), .MIN_FRAMES(MIN_FRAMES)) u_sweep (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .busy       (busy),
      .frame_pulse(frame_pulse),
      .fill_we    (fill_we),
      .fill_addr  (fill_addr),
      .done       (done)
   );

   cmf_wport #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .FILL_W(FILL_W), .HI_FIELD_W(HI_FIELD_W)
   ) u_wport (
      .fill_we  (fill_we),
      .fill_addr(fill_addr),
      .fill_val (fill_val),
      .locked   (busy || arm || blocked),
      .cpu_wr_lo(cpu_wr_lo),
      .cpu_wr_hi(cpu_wr_hi),
      .cpu_addr (cpu_addr),
      .cpu_dlo  (cpu_dlo),
      .cpu_dhi  (cpu_dhi),
      .cm_we_lo (cm_we_lo),
      .cm_we_hi (cm_we_hi),
      .cm_addr  (cm_addr),
      .cm_dlo   (cm_dlo),
      .cm_dhi   (cm_dhi),
      .cpu_rej  (cpu_rej)
   );

   assign stat_busy     = busy;
   assign stat_arm      = arm;
   assign stat_start    = start;
   assign stat_blocked  = blocked;
   assign stat_fill_val = fill_val;

   // R4
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(stat_busy) && !$past(reg_wr)) |-> $past(frame_pulse));
   // R8
   cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cm_we_lo || cm_we_hi) && !stat_busy) |-> (!stat_arm && !stat_blocked));
   // R3
   fill_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_busy && cm_we_hi) |-> (cm_dhi == '0));
endmodule

// File: tb/tb_cm_fill_engine.sv
module tb_cm_fill_engine;
   localparam int DEPTH = 16;
   localparam int AW    = 4;

   logic          clk = 1'b0;
   logic          rst_n, frame_pulse, reg_wr, reg_addr;
   logic [3:0]    reg_wdata;
   logic          cpu_wr_lo, cpu_wr_hi;
   logic [AW-1:0] cpu_addr;
   logic [15:0]   cpu_dlo, cpu_dhi;
   logic          cm_we_lo, cm_we_hi, cpu_rej;
   logic [AW-1:0] cm_addr;
   logic [15:0]   cm_dlo, cm_dhi;
   logic          stat_busy, stat_arm, stat_start, stat_blocked;
   logic [2:0]    stat_fill_val;

   always #10 clk = ~clk;

   cm_fill_engine #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .cpu_wr_lo(cpu_wr_lo), .cpu_wr_hi(cpu_wr_hi), .cpu_addr(cpu_addr),
      .cpu_dlo(cpu_dlo), .cpu_dhi(cpu_dhi),
      .cm_we_lo(cm_we_lo), .cm_we_hi(cm_we_hi), .cm_addr(cm_addr),
      .cm_dlo(cm_dlo), .cm_dhi(cm_dhi), .cpu_rej(cpu_rej),
      .stat_busy(stat_busy), .stat_arm(stat_arm), .stat_start(stat_start),
      .stat_blocked(stat_blocked), .stat_fill_val(stat_fill_val)
   );

   int errors = 0;
   int checks = 0;
   int wr_count = 0;
   int seq_err = 0;
   logic [AW-1:0] seq_exp = '0;
   logic [15:0] mlo [DEPTH];
   logic [15:0] mhi [DEPTH];

   // memory model plus an order monitor for fill writes
   always @(posedge clk) begin
      if (cm_we_lo) mlo[cm_addr] <= cm_dlo;
      if (cm_we_hi) mhi[cm_addr] <= cm_dhi;
      if (cm_we_lo || cm_we_hi) wr_count <= wr_count + 1;
      if (cm_we_lo && stat_busy) begin
         if (cm_addr !== seq_exp) seq_err <= seq_err + 1;
         seq_exp <= cm_addr + 1'b1;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic a, input logic [3:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_arm(input logic b);
      reg_write(1'b0, {b, 3'b000});
   endtask

   task automatic set_mode(input logic st, input logic [2:0] v);
      reg_write(1'b1, {v, st});
   endtask

   task automatic pulse_frame();
      frame_pulse = 1'b1;
      @(negedge clk);
      frame_pulse = 1'b0;
      @(negedge clk);
   endtask

   task automatic cpu_write(input logic [AW-1:0] a, input logic [15:0] lo,
                            input logic [15:0] hi, input logic exp_rej, input string req);
      cpu_wr_lo = 1'b1; cpu_wr_hi = 1'b1; cpu_addr = a; cpu_dlo = lo; cpu_dhi = hi;
      #1;
      chk(req, "cpu_rej", int'(cpu_rej), int'(exp_rej));
      @(negedge clk);
      cpu_wr_lo = 1'b0; cpu_wr_hi = 1'b0;
   endtask

   task automatic check_range(input int first, input int last, input logic [15:0] lo, input string req);
      for (int i = first; i <= last; i++) begin
         chk(req, $sformatf("lo[%0d]", i), int'(mlo[i]), int'(lo));
         chk(req, $sformatf("hi[%0d]", i), int'(mhi[i]), 0);
      end
   endtask

   // R1
   task automatic t_reset();
      chk("R1", "busy", int'(stat_busy), 0);
      chk("R1", "arm", int'(stat_arm), 0);
      chk("R1", "start", int'(stat_start), 0);
      chk("R1", "blocked", int'(stat_blocked), 0);
      chk("R1", "we", int'(cm_we_lo || cm_we_hi), 0);
   endtask

   // R8: open access while idle, reserved high bits dropped
   task automatic t_cpu_open();
      for (int i = 0; i < DEPTH; i++) cpu_write(AW'(i), 16'hFFFF, 16'hFFFF, 1'b0, "R8");
      @(negedge clk);
      chk("R8", "lo pass", int'(mlo[3]), 16'hFFFF);
      chk("R8", "hi masked", int'(mhi[3]), 16'h001F);
   endtask

   // R2: start without arm makes no fill
   task automatic t_start_unarmed();
      int w0;
      w0 = wr_count;
      set_mode(1'b1, 3'd4);
      repeat (20) @(negedge clk);
      chk("R2", "busy unarmed", int'(stat_busy), 0);
      chk("R2", "no writes", wr_count - w0, 0);
      chk("R7", "blocked", int'(stat_blocked), 1);
      cpu_write(AW'(2), 16'h0, 16'h0, 1'b1, "R8");
      @(negedge clk);
      chk("R8", "refused unchanged", int'(mlo[2]), 16'hFFFF);
      set_mode(1'b0, 3'd4);
      chk("R7", "blocked cleared", int'(stat_blocked), 0);
   endtask

   // R3 R4 R5: full fill, frames dominate
   task automatic t_full_fill();
      int w0;
      set_arm(1'b1);
      w0 = wr_count; seq_exp = '0; seq_err = 0;
      set_mode(1'b1, 3'd5);
      chk("R2", "busy after start", int'(stat_busy), 1);
      repeat (24) @(negedge clk);
      chk("R4", "busy no frames", int'(stat_busy), 1);
      chk("R3", "one write per location", wr_count - w0, DEPTH);
      chk("R3", "ascending order", seq_err, 0);
      pulse_frame();
      pulse_frame();
      chk("R4", "busy after two frames", int'(stat_busy), 1);
      pulse_frame();
      chk("R4", "done at third frame", int'(stat_busy), 0);
      chk("R5", "start cleared", int'(stat_start), 0);
      chk("R5", "arm kept", int'(stat_arm), 1);
      check_range(0, DEPTH - 1, 16'h0005, "R3");
      cpu_write(AW'(7), 16'h1111, 16'h0, 1'b1, "R8");
      @(negedge clk);
      chk("R8", "armed refused", int'(mlo[7]), 16'h0005);
   endtask

   // R4: frames early, completion waits for sweep end and a later pulse
   task automatic t_frames_early();
      set_mode(1'b1, 3'd2);
      pulse_frame();
      pulse_frame();
      pulse_frame();
      repeat (20) @(negedge clk);
      chk("R4", "busy after sweep without pulse", int'(stat_busy), 1);
      pulse_frame();
      chk("R4", "done on next pulse", int'(stat_busy), 0);
      check_range(0, DEPTH - 1, 16'h0002, "R3");
   endtask

   // R6: abort by clearing start
   task automatic t_abort_start();
      int w0;
      set_mode(1'b1, 3'd6);
      repeat (5) @(negedge clk);
      set_mode(1'b0, 3'd6);
      chk("R6", "busy after abort", int'(stat_busy), 0);
      chk("R6", "start", int'(stat_start), 0);
      w0 = wr_count;
      repeat (10) @(negedge clk);
      chk("R6", "no writes after abort", wr_count - w0, 0);
      check_range(0, 5, 16'h0006, "R6");
      chk("R6", "lo[6] untouched", int'(mlo[6]), 16'h0002);
   endtask

   // R7: abort by clearing arm
   task automatic t_abort_arm();
      set_mode(1'b1, 3'd1);
      repeat (3) @(negedge clk);
      set_arm(1'b0);
      chk("R7", "busy", int'(stat_busy), 0);
      chk("R7", "start kept", int'(stat_start), 1);
      chk("R7", "blocked", int'(stat_blocked), 1);
      repeat (4) @(negedge clk);
      chk("R7", "lo[3]", int'(mlo[3]), 16'h0001);
      chk("R7", "lo[4] untouched", int'(mlo[4]), 16'h0006);
      cpu_write(AW'(4), 16'h1234, 16'h00AA, 1'b1, "R8");
      set_mode(1'b0, 3'd1);
      chk("R7", "unblocked", int'(stat_blocked), 0);
      cpu_write(AW'(4), 16'h1234, 16'h00AA, 1'b0, "R8");
      @(negedge clk);
      chk("R8", "lo accepted", int'(mlo[4]), 16'h1234);
      chk("R8", "hi reserved zero", int'(mhi[4]), 16'h000A);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; frame_pulse = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
      cpu_wr_lo = 1'b0; cpu_wr_hi = 1'b0; cpu_addr = '0; cpu_dlo = '0; cpu_dhi = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cpu_open();
      t_start_unarmed();
      t_full_fill();
      t_frames_early();
      t_abort_start();
      t_abort_arm();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule